// File: doc/BRIEF.md
# Block transfer address sequencer

This block produces the sequence of word addresses for a multi-register load or store. A single start strobe captures a base address, a 16-bit register-select mask, a two-bit direction/timing mode and a writeback enable. The block then emits one transfer per selected register. Each transfer carries a word address and the index of the register it belongs to, and is offered on a valid/ready handshake. Memory and the register file sit outside the block; it only orders the addresses and indices.

Registers always go out in ascending index order, and the lowest selected index always lands at the lowest address, whichever way the mode runs. The mode picks whether the block walks upward or downward from the base, and whether the base is adjusted before or after the first access. In the cycle after the last transfer is accepted, the block pulses done. In that same cycle it presents the updated base, which is qualified by the writeback enable that was captured at start.

Top module: `blk_addr_seq`

## Requirements
- R1: After a synchronous reset, out_valid, done and wb_valid are all low.
- R2: Mode 2'b00 (ascending, adjust after) puts the first transfer at the base address with its two low bits cleared.
- R3: Mode 2'b01 (ascending, adjust before) puts the first transfer one word (4 bytes) above the aligned base.
- R4: Mode 2'b10 (descending, adjust after) puts the first transfer at the aligned base minus 4 times the number of selected registers, plus 4.
- R5: Mode 2'b11 (descending, adjust before) puts the first transfer at the aligned base minus 4 times the number of selected registers.
- R6: Each selected register gets exactly one transfer. Transfers come in ascending register index order, and each address is the previous one plus 4. Bits [1:0] of every address are zero.
- R7: While out_valid is high and out_ready is low, out_valid, out_addr and out_idx hold their values.
- R8: done is high for exactly one cycle, the cycle after the last transfer is accepted. In that cycle wb_addr equals the aligned base plus 4 times the count for modes 00 and 01, or minus 4 times the count for modes 10 and 11. wb_valid equals done AND the captured writeback enable.
- R9: A start with an all-zero mask issues no transfer. It raises done in the next cycle, with wb_addr equal to the aligned base.
- R10: A start strobe that arrives while a sequence is in progress (before done) is ignored. The running sequence is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| base_addr | input | 32 | Base byte address |
| reg_mask | input | 16 | Register-select mask, bit i selects register i |
| mode | input | 2 | 00 up/after, 01 up/before, 10 down/after, 11 down/before |
| wb_en | input | 1 | Request base writeback at the end |
| out_valid | output | 1 | Transfer offered |
| out_ready | input | 1 | Transfer accepted by consumer |
| out_addr | output | 32 | Word address of the offered transfer |
| out_idx | output | 4 | Register index of the offered transfer |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback value is to be written |
| wb_addr | output | 32 | Updated base value |

## Verification
Every mode is run with a sparse mask, so start-address errors can be told apart from step errors. A full mask and single-bit masks at both ends of the index range expose count and priority mistakes. A base with nonzero low bits checks alignment, and a small base in the descending modes forces the address to wrap below zero. Ready is driven always-high and also with stall patterns, which separates hold behaviour from stepping. A zero mask and a start strobe raised mid-sequence cover the empty and ignored-start cases. The writeback enable is toggled between runs to check that wb_valid gating is independent of the address value.

// File: rtl/blk_seq_pkg.sv
package blk_seq_pkg;

    typedef enum logic [1:0] {
        MODE_UP_AFTER   = 2'b00,
        MODE_UP_BEFORE  = 2'b01,
        MODE_DN_AFTER   = 2'b10,
        MODE_DN_BEFORE  = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIN  = 2'b10
    } seq_state_e;

    localparam int WORD_BYTES = 4;

    function automatic logic mode_is_down(input xfer_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_is_before(input xfer_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/blk_seq_plan.sv
module blk_seq_plan
    import blk_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [NREG-1:0]   mask,
    input  xfer_mode_e        mode,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] final_addr
);
    localparam int CNT_W = $clog2(NREG + 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [CNT_W-1:0]  sel_cnt;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] aligned;

    always_comb begin
        sel_cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            sel_cnt = sel_cnt + CNT_W'(mask[i]);
        end
    end

    assign span    = ADDR_W'(sel_cnt) * STEP;
    assign aligned = {base[ADDR_W-1:2], 2'b00};

    always_comb begin
        if (mode_is_down(mode)) begin
            final_addr = aligned - span;
            first_addr = mode_is_before(mode) ? (aligned - span)
                                              : (aligned - span + STEP);
        end else begin
            final_addr = aligned + span;
            first_addr = mode_is_before(mode) ? (aligned + STEP) : aligned;
        end
    end

endmodule

// File: rtl/blk_seq_pick.sv
module blk_seq_pick #(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  pend,
    output logic [NREG-1:0]  low_hot,
    output logic [IDX_W-1:0] low_idx
);
    assign low_hot = pend & (~pend + NREG'(1));

    always_comb begin
        low_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (pend[i]) low_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/blk_addr_seq.sv
module blk_addr_seq
    import blk_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [NREG-1:0]   reg_mask,
    input  logic [1:0]        mode,
    input  logic              wb_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [IDX_W-1:0]  out_idx,
    output logic              done,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    seq_state_e        state;
    logic [NREG-1:0]   pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wb_q;
    logic              wb_en_q;

    logic [ADDR_W-1:0] plan_first;
    logic [ADDR_W-1:0] plan_final;
    logic [NREG-1:0]   low_hot;
    logic [IDX_W-1:0]  low_idx;
    logic [NREG-1:0]   pend_rest;
    logic              fire;

    blk_seq_plan #(.ADDR_W(ADDR_W), .NREG(NREG)) plan_i (
        .base       (base_addr),
        .mask       (reg_mask),
        .mode       (xfer_mode_e'(mode)),
        .first_addr (plan_first),
        .final_addr (plan_final)
    );

    blk_seq_pick #(.NREG(NREG), .IDX_W(IDX_W)) pick_i (
        .pend    (pend_q),
        .low_hot (low_hot),
        .low_idx (low_idx)
    );

    assign fire      = (state == ST_RUN) && out_ready;
    assign pend_rest = pend_q & ~low_hot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pend_q  <= '0;
            addr_q  <= '0;
            wb_q    <= '0;
            wb_en_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pend_q  <= reg_mask;
                        addr_q  <= plan_first;
                        wb_q    <= plan_final;
                        wb_en_q <= wb_en;
                        state   <= (reg_mask == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (fire) begin
                        pend_q <= pend_rest;
                        addr_q <= addr_q + STEP;
                        if (pend_rest == '0) state <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign out_valid = (state == ST_RUN);
    assign out_addr  = addr_q;
    assign out_idx   = low_idx;
    assign done      = (state == ST_FIN);
    assign wb_valid  = done && wb_en_q;
    assign wb_addr   = wb_q;

    // R7: offered transfer is held under back-pressure
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_idx)));

    // R6: consecutive transfers step by one word
    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && $countones(pend_q) > 1) |=> (out_valid && out_addr == $past(out_addr) + STEP));

    // R6: addresses are word aligned
    p_align_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_addr[1:0] == 2'b00));

    // R8: completion follows the last accepted transfer and lasts one cycle
    p_last_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && $countones(pend_q) == 1) |=> (done && !out_valid));

    p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: empty mask completes at once
    p_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !done && start && reg_mask == '0) |=> (done && !out_valid));

endmodule

// File: tb/blk_addr_seq_tb_top.sv
module blk_addr_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] reg_mask = '0;
    logic [1:0]  mode = '0;
    logic        wb_en = 1'b0;
    logic        out_ready = 1'b1;
    logic        out_valid, done, wb_valid;
    logic [31:0] out_addr, wb_addr;
    logic [3:0]  out_idx;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rdy_pat = 0;
    bit chk_en = 0;

    blk_addr_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .reg_mask(reg_mask), .mode(mode), .wb_en(wb_en),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_idx(out_idx), .done(done), .wb_valid(wb_valid), .wb_addr(wb_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    int          m_st = 0;        // 0 idle, 1 running, 2 finishing
    logic [31:0] q_addr[$];
    int          q_idx[$];
    logic [31:0] m_wb;
    bit          m_wben, m_first, m_stall, m_empty, m_ign;
    logic [1:0]  m_mode;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            m_st = 0;
            q_addr.delete(); q_idx.delete();
        end else begin
            case (m_st)
                0: if (start) begin
                    int n;
                    logic [31:0] al, fa;
                    n = 0;
                    for (int i = 0; i < 16; i++) if (reg_mask[i]) n++;
                    al = {base_addr[31:2], 2'b00};
                    case (mode)
                        2'b00: fa = al;
                        2'b01: fa = al + 32'd4;
                        2'b10: fa = al - 32'(4*n) + 32'd4;
                        default: fa = al - 32'(4*n);
                    endcase
                    m_wb = mode[1] ? al - 32'(4*n) : al + 32'(4*n);
                    q_addr.delete(); q_idx.delete();
                    for (int i = 0, k = 0; i < 16; i++) if (reg_mask[i]) begin
                        q_addr.push_back(fa + 32'(4*k));
                        q_idx.push_back(i);
                        k++;
                    end
                    m_wben = wb_en; m_mode = mode; m_first = 1;
                    m_stall = 0; m_ign = 0; m_empty = (n == 0);
                    m_st = (n == 0) ? 2 : 1;
                end
                1: begin
                    if (start) m_ign = 1;
                    if (out_ready) begin
                        void'(q_addr.pop_front()); void'(q_idx.pop_front());
                        m_first = 0; m_stall = 0;
                        if (q_addr.size() == 0) m_st = 2;
                    end else m_stall = 1;
                end
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic string addr_tag();
        if (m_ign) return "R10";
        if (m_stall) return "R7";
        if (!m_first) return "R6";
        case (m_mode)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    // compare on every falling edge
    always @(negedge clk) begin
        if (chk_en) begin
            if (rst) begin
                chk("R1 out_valid", 32'(out_valid), 0);
                chk("R1 done", 32'(done), 0);
                chk("R1 wb_valid", 32'(wb_valid), 0);
            end else begin
                chk(m_ign ? "R10 out_valid" : (m_empty ? "R9 out_valid" : "R6 out_valid"),
                    32'(out_valid), 32'(m_st == 1));
                chk(m_empty ? "R9 done" : "R8 done", 32'(done), 32'(m_st == 2));
                chk("R8 wb_valid", 32'(wb_valid), 32'(m_st == 2 && m_wben));
                if (m_st == 1 && q_addr.size() > 0) begin
                    chk(addr_tag(), out_addr, q_addr[0]);
                    chk(m_stall ? "R7 idx" : "R6 idx", 32'(out_idx), 32'(q_idx[0]));
                end
                if (m_st == 2)
                    chk(m_empty ? "R9 wb_addr" : "R8 wb_addr", wb_addr, m_wb);
            end
        end
        out_ready <= (rdy_pat == 0) ? 1'b1 : ((cyc % rdy_pat) != 0);
    end

    task automatic run(input logic [31:0] b, input logic [15:0] m,
                       input logic [1:0] md, input bit we, input bit poke);
        @(negedge clk);
        base_addr = b; reg_mask = m; mode = md; wb_en = we; start = 1;
        @(negedge clk);
        start = 0;
        if (poke) begin
            @(negedge clk);
            base_addr = 32'h5555_0000; reg_mask = 16'h00FF; mode = ~md; wb_en = ~we; start = 1;
            @(negedge clk);
            start = 0;
        end
        while (m_st != 0) @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk_en = 1;
        @(negedge clk);
        rst = 0;
        for (int md = 0; md < 4; md++) begin
            rdy_pat = 0;
            run(32'h0000_1000, 16'h00B1, 2'(md), 1, 0);
            rdy_pat = 3;
            run(32'h0000_2003, 16'h8421, 2'(md), 0, 0);
            rdy_pat = 2;
            run(32'h0000_0008, 16'hFFFF, 2'(md), 1, 0);
            rdy_pat = 0;
            run(32'h8000_0000, 16'h8000, 2'(md), 1, 0);
            run(32'h0000_0040, 16'h0001, 2'(md), 1, 0);
            run(32'h0000_3000, 16'h0000, 2'(md), 1, 0);
            rdy_pat = 4;
            run(32'h0000_4000, 16'h0F0F, 2'(md), 1, 1);
        end
        rdy_pat = 0;
        run(32'hFFFF_FFFC, 16'h0003, 2'b01, 1, 0);
        run(32'h0000_0010, 16'h0000, 2'b10, 0, 0);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule